// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the settings a frequency synthesizer needs for its dividers: a 9-bit feedback divide value M, a 2-bit output divide value N, and a 2-bit test-select code T. There are two ways to load them. In parallel mode, M and N come from pins that can be hardwired, so a default setting takes effect at power-up. In serial mode, a 14-bit frame is clocked in on a serial clock and data pair, and a load strobe moves the frame into the setting registers. If the strobe stays high, the setting registers follow the shift register on every serial clock edge.

The block also drives a TEST pin through a 4-way selector. The selector is controlled by T and can output constant low, the serial data, the M-divider feedback, or the synthesizer output clock. The pre-divider select follows its own dedicated pin and nothing else. A status flag goes high while the active M value lies outside the range in which lock is expected.

The parallel-load enable, the pre-divider pin and all serial pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected in the system clock domain. A setting output therefore changes 3 system clocks after the pin edge that causes it. The parallel M and N pins are treated as quasi-static and are sampled without a synchronizer.

Top module: `divcfg_loader`

## Requirements
- R1: While par_load_ni is low, m_o and n_o follow par_m_i and par_n_i, within 4 system clocks of any change.
- R2: When par_load_ni rises, the current par_m_i and par_n_i values are captured. They are then held, whatever the parallel pins do, until par_load_ni goes low again or a serial load occurs.
- R3: While par_load_ni is high, each rising edge of ser_clk_i shifts ser_data_i into a 14-bit register. The first bit shifted in is T1. The frame order, first to last, is T1, T0, one unused slot, N1, N0, M8 down to M0.
- R4: The unused frame slot is clocked like any other bit. Its value does not affect m_o, n_o or the test-select code.
- R5: A rising edge of ser_load_i, while par_load_ni is high, moves the shift register's M, N and T fields into the setting registers. After ser_load_i falls, further shifting leaves the settings unchanged.
- R6: While ser_load_i is held high, every ser_clk_i rising edge shifts one bit and loads the new shift register contents into the settings at once.
- R7: With par_load_ni high, test_o is selected by T = {T1,T0}: 00 gives 0, 01 gives ser_data_i, 10 gives mdiv_fb_i, and 11 gives fout_cmos_i.
- R8: test_o is 0 whenever par_load_ni is low.
- R9: p_sel_o follows p_pin_i only (0 = divide-by-1, 1 = alternate ratio). It resets to 0, and serial loads never change it.
- R10: Reset sets M = 25, N = 0 and T = 00. A parallel load never changes T.
- R11: m_range_err_o is 1 exactly when the active M value is below 23 or above 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_load_ni | input | 1 | Parallel-load enable, active low; high selects the serial path |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide value |
| p_pin_i | input | 1 | Pre-divider select pin |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, first bit T1 |
| ser_load_i | input | 1 | Serial load strobe |
| mdiv_fb_i | input | 1 | M-divider output, for the test selector |
| fout_cmos_i | input | 1 | Synthesizer output clock, for the test selector |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 2 | Active output divide value |
| p_sel_o | output | 1 | Pre-divider select |
| test_o | output | 1 | Test pin |
| m_range_err_o | output | 1 | Active M value is outside 23..27 |

## Verification
Assertions check the following on every cycle:
- the parallel settings are tracked while par_load_ni is low;
- the settings hold when no load event occurs;
- T stays unchanged during parallel mode;
- TEST is low in parallel mode;
- the shift register takes in exactly one bit per shift and keeps its contents otherwise;
- the pre-divider select ignores everything except its pin.

Only the bench scenarios can show the following:
- the field positions inside the frame and that the unused slot has no effect;
- latching when the strobe falls and tracking while it is held high;
- each of the four test-selector codes;
- the boundary values of the lock-range flag.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 1 + N_W + M_W;

  // MSB is the first bit shifted in
  typedef struct packed {
    logic [T_W-1:0] t;
    logic           nul;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } frame_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_MDIV  = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else            stage_q[g] <= stage_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] sr_nxt_o
);
  logic [W-1:0] sr_q;

  assign sr_nxt_o = {sr_q[W-2:0], bit_i};
  assign sr_o     = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= sr_nxt_o;
  end

  assert_shift_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[0] == $past(bit_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  assert_shift_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import divcfg_pkg::*;
(
  input  tsel_e sel_i,
  input  logic  par_mode_i,
  input  logic  sdata_i,
  input  logic  mdiv_i,
  input  logic  fout_i,
  output logic  test_o
);
  always_comb begin
    unique case (sel_i)
      TSEL_LOW:   test_o = 1'b0;
      TSEL_SDATA: test_o = sdata_i;
      TSEL_MDIV:  test_o = mdiv_i;
      TSEL_FOUT:  test_o = fout_i;
      default:    test_o = 1'b0;
    endcase
    if (par_mode_i) test_o = 1'b0;
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [8:0]  M_RST       = 9'd25,
  parameter logic [8:0]  M_LOCK_MIN  = 9'd23,
  parameter logic [8:0]  M_LOCK_MAX  = 9'd27
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           p_pin_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           mdiv_fb_i,
  input  logic           fout_cmos_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic           p_sel_o,
  output logic           test_o,
  output logic           m_range_err_o
);
  localparam int NSYNC = 5;

  // {p_pin, ser_load, ser_clk, ser_data, par_load_n}
  logic [NSYNC-1:0] pins_s;
  logic par_s, sdata_s, sclk_s, ld_s, p_s;
  logic sclk_q, ld_q;
  logic sclk_rise, ld_rise, shift;
  logic [FRAME_W-1:0] sr, sr_nxt;
  frame_t fr_cur, fr_nxt;

  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic [T_W-1:0] t_q;
  logic           p_q;

  cfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({p_pin_i, ser_load_i, ser_clk_i, ser_data_i, par_load_ni}),
    .q_o   (pins_s)
  );

  assign {p_s, ld_s, sclk_s, sdata_s, par_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ld_q   <= ld_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign ld_rise   = ld_s & ~ld_q;
  assign shift     = par_s & sclk_rise;

  cfg_shifter #(.W(FRAME_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (sdata_s),
    .sr_o    (sr),
    .sr_nxt_o(sr_nxt)
  );

  assign fr_cur = frame_t'(sr);
  assign fr_nxt = frame_t'(sr_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= M_RST;
      n_q <= '0;
      t_q <= '0;
      p_q <= 1'b0;
    end else begin
      p_q <= p_s;
      if (!par_s) begin
        m_q <= par_m_i;
        n_q <= par_n_i;
      end else if (ld_s && sclk_rise) begin
        // strobe held high: settings track each shift
        m_q <= fr_nxt.m;
        n_q <= fr_nxt.n;
        t_q <= fr_nxt.t;
      end else if (ld_rise) begin
        m_q <= fr_cur.m;
        n_q <= fr_cur.n;
        t_q <= fr_cur.t;
      end
    end
  end

  cfg_test_mux u_test_mux (
    .sel_i     (tsel_e'(t_q)),
    .par_mode_i(~par_s),
    .sdata_i   (sdata_s),
    .mdiv_i    (mdiv_fb_i),
    .fout_i    (fout_cmos_i),
    .test_o    (test_o)
  );

  assign m_o           = m_q;
  assign n_o           = n_q;
  assign p_sel_o       = p_q;
  assign m_range_err_o = (m_q < M_LOCK_MIN) || (m_q > M_LOCK_MAX);

  assert_par_track_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |=> (m_q == $past(par_m_i)) && (n_q == $past(par_n_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !ld_rise && !(ld_s && sclk_rise)) |=> ($stable(m_q) && $stable(n_q)));

  assert_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !ld_s) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));

  assert_test_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |-> !test_o);

  assert_psel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(p_s) |=> $stable(p_sel_o));

  assert_t_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_s |=> $stable(t_q));
endmodule

// File: tb/divcfg_loader_tb.sv
module divcfg_loader_tb;
  localparam int NV     = 6;
  localparam int SETTLE = 5;
  localparam logic [8:0] VEC_M [NV] = '{9'd23, 9'd27, 9'd22, 9'd28, 9'd511, 9'd0};
  localparam logic [1:0] VEC_N [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_load_n = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic p_pin = 1'b0, sclk = 1'b0, sdata = 1'b0, sload = 1'b0, mdiv = 1'b0, fout = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic p_sel, test, m_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [13:0] exp_sr;

  always #10 clk = ~clk;

  divcfg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .par_load_ni(par_load_n),
    .par_m_i(par_m), .par_n_i(par_n), .p_pin_i(p_pin),
    .ser_clk_i(sclk), .ser_data_i(sdata), .ser_load_i(sload),
    .mdiv_fb_i(mdiv), .fout_cmos_i(fout),
    .m_o(m_o), .n_o(n_o), .p_sel_o(p_sel), .test_o(test), .m_range_err_o(m_err)
  );

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    wait_c(SETTLE);
    sclk = 1'b1;
    wait_c(SETTLE);
    sclk = 1'b0;
    wait_c(SETTLE);
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic strobe();
    sload = 1'b1;
    wait_c(SETTLE);
    sload = 1'b0;
    wait_c(SETTLE);
  endtask

  function automatic logic [13:0] mk(input logic [1:0] t, input logic nul,
                                     input logic [1:0] n, input logic [8:0] m);
    return {t, nul, n, m};
  endfunction

  initial begin
    wait_c(3);
    rst_n = 1'b1;
    wait_c(SETTLE);

    // reset state
    check("R10 reset M", m_o, 25);
    check("R10 reset N", n_o, 0);
    mdiv = 1'b1; fout = 1'b1; sdata = 1'b1;
    wait_c(SETTLE);
    check("R10 reset T=00 gives test low", test, 0);
    check("R9 reset p_sel", p_sel, 0);
    check("R11 reset flag", m_err, 0);
    mdiv = 1'b0; fout = 1'b0; sdata = 1'b0;

    // vector table: serial frames
    for (int v = 0; v < NV; v++) begin
      send_frame(mk(2'b00, 1'b0, VEC_N[v], VEC_M[v]));
      strobe();
      check("R3 serial M field", m_o, VEC_M[v]);
      check("R3 serial N field", n_o, VEC_N[v]);
      check("R11 range flag", m_err, (VEC_M[v] < 23 || VEC_M[v] > 27) ? 1 : 0);
    end

    // test mux selections
    send_frame(mk(2'b01, 1'b0, 2'd1, 9'd25));
    strobe();
    sdata = 1'b1; wait_c(SETTLE);
    check("R7 T=01 sdata high", test, 1);
    sdata = 1'b0; wait_c(SETTLE);
    check("R7 T=01 sdata low", test, 0);
    send_frame(mk(2'b10, 1'b0, 2'd1, 9'd25));
    strobe();
    mdiv = 1'b1; wait_c(SETTLE);
    check("R7 T=10 mdiv high", test, 1);
    mdiv = 1'b0; wait_c(SETTLE);
    check("R7 T=10 mdiv low", test, 0);
    send_frame(mk(2'b11, 1'b0, 2'd1, 9'd25));
    strobe();
    fout = 1'b1; wait_c(SETTLE);
    check("R7 T=11 fout high", test, 1);
    fout = 1'b0; wait_c(SETTLE);
    check("R7 T=11 fout low", test, 0);

    // NULL slot set: no effect on fields
    send_frame(mk(2'b00, 1'b1, 2'd2, 9'd24));
    strobe();
    check("R4 null ignored M", m_o, 24);
    check("R4 null ignored N", n_o, 2);
    mdiv = 1'b1; fout = 1'b1; sdata = 1'b1; wait_c(SETTLE);
    check("R4 null ignored T stays 00", test, 0);
    mdiv = 1'b0; fout = 1'b0; sdata = 1'b0;

    // latch after strobe falls
    send_frame(mk(2'b00, 1'b0, 2'd3, 9'd26));
    check("R5 held after strobe fall M", m_o, 24);
    check("R5 held after strobe fall N", n_o, 2);
    strobe();
    check("R5 strobe rise loads M", m_o, 26);
    check("R5 strobe rise loads N", n_o, 3);

    // strobe held high: tracking
    sload = 1'b1;
    wait_c(SETTLE);
    exp_sr = mk(2'b00, 1'b0, 2'd1, 9'd23);
    send_frame(exp_sr);
    check("R6 tracking M", m_o, 23);
    check("R6 tracking N", n_o, 1);
    shift_bit(1'b1);
    exp_sr = {exp_sr[12:0], 1'b1};
    check("R6 extra shift M", m_o, exp_sr[8:0]);
    check("R6 extra shift N", n_o, exp_sr[10:9]);
    sload = 1'b0;
    wait_c(SETTLE);

    // set T=01, then parallel mode
    send_frame(mk(2'b01, 1'b0, 2'd0, 9'd25));
    strobe();
    sdata = 1'b1; wait_c(SETTLE);
    check("R7 T=01 before parallel", test, 1);
    par_m = 9'd100; par_n = 2'd3;
    par_load_n = 1'b0;
    wait_c(SETTLE);
    check("R8 test low in parallel mode", test, 0);
    check("R1 parallel M", m_o, 100);
    check("R1 parallel N", n_o, 3);
    par_m = 9'd200; par_n = 2'd1;
    wait_c(SETTLE);
    check("R1 parallel follows M", m_o, 200);
    check("R1 parallel follows N", n_o, 1);
    check("R11 flag from parallel M", m_err, 1);
    par_load_n = 1'b1;
    wait_c(SETTLE);
    par_m = 9'd5; par_n = 2'd2;
    wait_c(SETTLE);
    check("R2 captured M held", m_o, 200);
    check("R2 captured N held", n_o, 1);
    check("R10 T unchanged by parallel load", test, 1);
    sdata = 1'b0;

    // pre-divider pin
    p_pin = 1'b1;
    wait_c(SETTLE);
    check("R9 p_sel follows pin", p_sel, 1);
    send_frame(mk(2'b00, 1'b0, 2'd0, 9'd0));
    strobe();
    check("R9 p_sel unchanged by serial", p_sel, 1);
    p_pin = 1'b0;
    wait_c(SETTLE);
    check("R9 p_sel back to divide-by-1", p_sel, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule